// File: doc/BRIEF.md
# Perceptron Consumer Set Predictor

This block guesses which processors will read a memory block after its next write. A small history table, addressed by a short hash of program-counter and address bits computed outside the block, keeps the last `DEPTH` sharer bitmaps for each entry. One perceptron per processor turns the whole stored history of an entry into a yes/no vote for that processor. Every perceptron sees the sharer history of all processors, not only its own. It can therefore learn positive and negative correlations between different processors. All table entries share one weight set.

A prediction request carries an index. Two clock edges later the block returns an `NPROC`-bit consumer bitmap with a valid strobe. An update carries an index and the consumer bitmap that was actually seen. In that cycle the block recomputes every perceptron's sum from the current weights and the entry's current history. It retrains the weights where the rule calls for it, then pushes the new bitmap into that entry's history.

Top module: `consumer_perceptron`

## Requirements
- R1: While `rst_n` is low, and at the first edge after release, `pred_vld` is low. Reset clears every weight and history bit to zero, so a prediction made before any update returns an all-zero bitmap.
- R2: `pred_vld` is high in exactly the cycle two rising edges after a cycle with `pred_req` high, and low otherwise.
- R3: History bit `b = d*NPROC + j` holds whether processor `j` was a sharer `d` updates ago (`d = 0` is newest). Perceptron `p` has weight `w[p][b]` for each such bit. Its sum adds `w[p][b]` when the bit is 1 and subtracts it when the bit is 0. Bit `p` of `pred_set` is 1 only when that sum is strictly greater than zero.
- R4: On an update, perceptron `p` trains when its recomputed vote differs from `upd_set[p]`, or when the absolute value of its sum is at most `thresh`. Otherwise its weights are unchanged.
- R5: When perceptron `p` trains, each weight `w[p][b]` rises by one if history bit `b` equals `upd_set[p]` and falls by one otherwise.
- R6: Weights are `WW`-bit two's complement values that saturate at their largest and smallest values and never wrap.
- R7: An update shifts the entry's history one step older, dropping the oldest bitmap, and stores `upd_set` as the newest bitmap. Other entries are untouched.
- R8: The update uses the weights and history present in its own cycle, not values from an earlier prediction.
- R9: When an update and a prediction request fall in the same cycle, the prediction reflects that update (history and weights). An update in the following cycle does not affect it.
- R10: A sharer pattern that rotates from processor to processor is learned, so after training each processor's vote follows the previous bitmap's holder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| thresh | input | WW+clog2(NPROC*DEPTH)+1 | Training threshold on the sum magnitude, unsigned |
| pred_req | input | 1 | Prediction request |
| pred_idx | input | IDX_W | History entry to predict from |
| pred_vld | output | 1 | Prediction result valid |
| pred_set | output | NPROC | Predicted consumer bitmap, bit p for processor p |
| upd_en | input | 1 | Update strobe |
| upd_idx | input | IDX_W | History entry to train and extend |
| upd_set | input | NPROC | Consumer bitmap actually observed |

## Verification
Prediction and update share both the history table and the weights, and they can fall in the same cycle on the same entry. The bench provokes this with a directed sequence in which the same-cycle outcome differs from a stale read. It also runs a long random phase over only eight entries, so that collisions and back-to-back updates are frequent. Each returned bitmap is judged against a bench model that applies the update before capturing the prediction, and a bitmap computed from pre-update state is reported as a failure.

// File: rtl/consumer_perceptron.sv
module consumer_perceptron #(
  parameter int NPROC = 4,
  parameter int DEPTH = 2,
  parameter int IDX_W = 3,
  parameter int WW    = 8,
  localparam int HB   = NPROC * DEPTH,
  localparam int SW   = WW + $clog2(HB) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SW-1:0]    thresh,
  input  logic             pred_req,
  input  logic [IDX_W-1:0] pred_idx,
  output logic             pred_vld,
  output logic [NPROC-1:0] pred_set,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [NPROC-1:0] upd_set
);
  localparam int ENT = 1 << IDX_W;
  localparam logic signed [WW-1:0] WMAX = {1'b0, {(WW-1){1'b1}}};
  localparam logic signed [WW-1:0] WMIN = {1'b1, {(WW-1){1'b0}}};

  logic [HB*WW-1:0] wt [NPROC];
  logic [HB-1:0]    hist [ENT];
  logic [HB*WW-1:0] wnext [NPROC];
  logic             req_q;
  logic [IDX_W-1:0] idx_q;

  function automatic logic signed [SW-1:0] dot(input logic [HB*WW-1:0] wv, input logic [HB-1:0] h);
    logic signed [SW-1:0] s;
    logic signed [SW-1:0] x;
    s = '0;
    for (int b = 0; b < HB; b++) begin
      x = SW'($signed(wv[b*WW +: WW]));
      s = h[b] ? s + x : s - x;
    end
    return s;
  endfunction

  logic [HB-1:0] uh;
  assign uh = hist[upd_idx];

  always_comb begin
    for (int p = 0; p < NPROC; p++) begin
      logic signed [SW-1:0] s;
      logic [SW-1:0]        mag;
      logic                 trn;
      logic signed [WW-1:0] cur;
      s   = dot(wt[p], uh);
      mag = s[SW-1] ? SW'(-s) : SW'(s);
      trn = ((s > 0) != upd_set[p]) || (mag <= thresh);
      wnext[p] = wt[p];
      for (int b = 0; b < HB; b++) begin
        cur = $signed(wt[p][b*WW +: WW]);
        if (trn) begin
          if (uh[b] == upd_set[p]) begin
            if (cur != WMAX) wnext[p][b*WW +: WW] = cur + 1'b1;
          end else begin
            if (cur != WMIN) wnext[p][b*WW +: WW] = cur - 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPROC; p++) wt[p] <= '0;
      for (int e = 0; e < ENT; e++) hist[e] <= '0;
    end else if (upd_en) begin
      for (int p = 0; p < NPROC; p++) wt[p] <= wnext[p];
      hist[upd_idx] <= HB'(uh << NPROC) | HB'(upd_set);
    end
  end

  logic [NPROC-1:0] vote;
  always_comb
    for (int p = 0; p < NPROC; p++) vote[p] = dot(wt[p], hist[idx_q]) > 0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      idx_q    <= '0;
      pred_vld <= 1'b0;
      pred_set <= '0;
    end else begin
      req_q    <= pred_req;
      idx_q    <= pred_idx;
      pred_vld <= req_q;
      pred_set <= req_q ? vote : '0;
    end
  end
endmodule

// File: rtl/consumer_perceptron_chk.sv
module consumer_perceptron_chk #(
  parameter int NPROC = 4,
  parameter int DEPTH = 2,
  parameter int WW    = 8,
  localparam int HB   = NPROC * DEPTH
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pred_req,
  input logic             pred_vld,
  input logic             upd_en,
  input logic [HB*WW-1:0] wt [NPROC]
);
  localparam logic signed [WW-1:0] WMAX = {1'b0, {(WW-1){1'b1}}};
  localparam logic signed [WW-1:0] WMIN = {1'b1, {(WW-1){1'b0}}};

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !pred_vld);

  // R2
  req_to_vld_chk: assert property (@(posedge clk) disable iff (!rst_n) pred_req |=> ##1 pred_vld);

  // R2
  vld_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n) pred_vld |-> $past(pred_req, 2));

  for (genvar p = 0; p < NPROC; p++) begin : g_p
    for (genvar b = 0; b < HB; b++) begin : g_b
      // R5
      weight_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $signed(wt[p][b*WW +: WW]) != $signed($past(wt[p][b*WW +: WW])) |->
          ($past(upd_en) &&
           ($signed(wt[p][b*WW +: WW]) - $signed($past(wt[p][b*WW +: WW])) == 1 ||
            $signed($past(wt[p][b*WW +: WW])) - $signed(wt[p][b*WW +: WW]) == 1)));
      // R6
      no_wrap_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $signed($past(wt[p][b*WW +: WW])) == WMAX |-> $signed(wt[p][b*WW +: WW]) != WMIN);
      // R6
      no_wrap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $signed($past(wt[p][b*WW +: WW])) == WMIN |-> $signed(wt[p][b*WW +: WW]) != WMAX);
    end
  end
endmodule

bind consumer_perceptron consumer_perceptron_chk #(.NPROC(NPROC), .DEPTH(DEPTH), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pred_req(pred_req), .pred_vld(pred_vld), .upd_en(upd_en), .wt(wt)
);

// File: tb/consumer_perceptron_tb.sv
module consumer_perceptron_tb;
  localparam int NP = 4, DP = 2, IW = 3, WW = 8;
  localparam int HB = NP * DP, SW = WW + $clog2(HB) + 1, ENT = 1 << IW;
  localparam int WHI = (1 << (WW - 1)) - 1, WLO = -(1 << (WW - 1));

  logic clk = 0, rst_n = 0;
  logic [SW-1:0] thresh = 10;
  logic pred_req = 0, upd_en = 0;
  logic [IW-1:0] pred_idx = 0, upd_idx = 0;
  logic [NP-1:0] upd_set = 0;
  logic pred_vld;
  logic [NP-1:0] pred_set;

  consumer_perceptron #(.NPROC(NP), .DEPTH(DP), .IDX_W(IW), .WW(WW)) u_dut (
    .clk(clk), .rst_n(rst_n), .thresh(thresh), .pred_req(pred_req), .pred_idx(pred_idx),
    .pred_vld(pred_vld), .pred_set(pred_set), .upd_en(upd_en), .upd_idx(upd_idx), .upd_set(upd_set));

  always #5 clk = ~clk;

  int nrun = 0, nfail = 0;
  int mw [NP][HB];
  logic [HB-1:0] mh [ENT];
  logic e1_v = 0, eo_v = 0;
  logic [NP-1:0] e1_s = 0, eo_s = 0;

  function automatic int msum(int p, logic [HB-1:0] h);
    int s = 0;
    for (int b = 0; b < HB; b++) s += h[b] ? mw[p][b] : -mw[p][b];
    return s;
  endfunction

  function automatic logic [NP-1:0] mpred(int idx);
    logic [NP-1:0] r;
    for (int p = 0; p < NP; p++) r[p] = msum(p, mh[idx]) > 0;
    return r;
  endfunction

  task automatic mupdate(int idx, logic [NP-1:0] act, int thr);
    logic [HB-1:0] h = mh[idx];
    for (int p = 0; p < NP; p++) begin
      int s = msum(p, h);
      int mag = s < 0 ? -s : s;
      if (((s > 0) != act[p]) || mag <= thr)
        for (int b = 0; b < HB; b++)
          if (h[b] == act[p]) begin if (mw[p][b] < WHI) mw[p][b]++; end
          else begin if (mw[p][b] > WLO) mw[p][b]--; end
    end
    mh[idx] = HB'(h << NP) | HB'(act);
  endtask

  task automatic mreset();
    for (int p = 0; p < NP; p++) for (int b = 0; b < HB; b++) mw[p][b] = 0;
    for (int e = 0; e < ENT; e++) mh[e] = '0;
    e1_v = 0; eo_v = 0; e1_s = 0; eo_s = 0;
  endtask

  task automatic chk(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
    nrun++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit rq, int ri, bit ue, int ui, logic [NP-1:0] us);
    pred_req = rq; pred_idx = IW'(ri); upd_en = ue; upd_idx = IW'(ui); upd_set = us;
    @(posedge clk); #1;
    eo_v = e1_v; eo_s = e1_s;
    if (ue) mupdate(ui, us, int'(thresh));
    e1_v = rq; e1_s = rq ? mpred(ri) : '0;
    @(negedge clk);
    chk({tag, " vld"}, {3'b0, pred_vld}, {3'b0, eo_v});
    if (eo_v) chk(tag, pred_set, eo_s);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; pred_req = 0; upd_en = 0;
    mreset();
    @(negedge clk);
    chk("R1 vld in reset", {3'b0, pred_vld}, 4'b0);
    rst_n = 1;
  endtask

  logic [NP-1:0] last;

  initial begin
    void'($urandom(32'h5eed));
    mreset();
    repeat (3) @(negedge clk);
    chk("R1 vld in reset", {3'b0, pred_vld}, 4'b0);
    rst_n = 1;

    // R1 R2: first prediction after reset is all zero, latency two edges
    step("R1 first", 1, 4, 0, 0, 0);
    step("R2 gap", 0, 0, 0, 0, 0);
    chk("R1 zero bitmap", pred_set, 4'b0000);
    step("R2 idle", 0, 0, 0, 0, 0);

    // R9 R8: same-cycle collision, update result must be visible
    step("R7 push", 0, 0, 1, 2, 4'b1111);
    step("R9 collide", 1, 2, 1, 2, 4'b0000);
    step("R9 next-cycle upd", 0, 0, 1, 2, 4'b1010);
    chk("R9 collision result", pred_set, 4'b1111);
    step("R3 drain", 0, 0, 0, 0, 0);

    // R10: rotating single sharer
    do_reset();
    last = 4'b0001;
    for (int i = 0; i < 400; i++) begin
      step("R10 train", 0, 0, 1, 1, last);
      last = {last[NP-2:0], last[NP-1]};
    end
    step("R10 ask", 1, 1, 0, 0, 0);
    step("R10 wait", 0, 0, 0, 0, 0);
    chk("R10 rotation learned", pred_set, 4'b0001);

    // R6: weights saturate instead of wrapping
    do_reset();
    thresh = SW'(2000);
    for (int i = 0; i < 300; i++) step("R6 push", 0, 0, 1, 5, 4'b1111);
    step("R6 flip", 0, 0, 1, 5, 4'b0000);
    step("R6 refill", 0, 0, 1, 5, 4'b1111);
    step("R6 refill", 1, 5, 1, 5, 4'b1111);
    step("R6 wait", 0, 0, 0, 0, 0);
    chk("R6 saturated vote", pred_set, 4'b1111);

    // R3 R4 R5 R7 R8 R9: random mix checked against the model
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) begin
        case ($urandom_range(0, 3))
          0: thresh = 0;
          1: thresh = 10;
          2: thresh = 40;
          default: thresh = SW'(2000);
        endcase
      end
      step("R3 R4 R5 R7 R8 random", ($urandom_range(0, 2) != 0), $urandom_range(0, ENT - 1),
           $urandom_range(0, 1) == 1, $urandom_range(0, ENT - 1),
           (i % 3 == 0) ? NP'($urandom) : {upd_set[0], upd_set[NP-1:1]});
    end
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    #2_000_000;
    nrun++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule